// File: doc/BRIEF.md
# Digit-Serial Polynomial-Basis Field Multiplier

The block multiplies two elements of the binary extension field GF(2^M) and reduces the result modulo a field polynomial of degree M. Elements use polynomial basis. Coefficient arithmetic is in GF(2), so addition is XOR. The multiplier operand is consumed from its highest-order coefficient downward, L bits at a time. Each group of L bits is handled by one cell in a linear chain of identical registered cells. Operands and partial products pass through that chain in one direction only.

The chain holds NSTEP = ceil(M/L) cells. The operands, the field polynomial and the partial product travel together from cell to cell. Every cell folds in one digit of the multiplier and hands its result to the next cell. A caller presents a pair with a valid strobe and receives the reduced product a fixed number of cycles later, in the same order. The same structure is built for any M and L. When L does not divide M, the multiplier is widened with leading zero digits, and those digits are consumed first.

Top module: `gf_dsm_mul`

## Requirements
- R1: When `out_valid` is high, `out_p` equals in_a(x)·in_b(x) mod (x^M + in_g(x)) for the pair that produced it. Bit i of in_a, in_b, in_g and out_p is the coefficient of x^i, and the x^M term of the field polynomial is implied.
- R2: A multiplier equal to 1 (only bit 0 set) returns in_a unchanged, and a multiplicand equal to 1 returns in_b unchanged.
- R3: A zero multiplicand or a zero multiplier gives a zero product.
- R4: The clock edge that samples `in_valid` high is followed, NSTEP-1 edges later, by an edge after which `out_valid` is high with that pair's result. For example, NSTEP = 1 means the result is visible right after the capturing edge.
- R5: Pairs may be presented on consecutive cycles. Each accepted pair produces exactly one `out_valid` pulse, and results leave in arrival order.
- R6: Pairs presented every NSTEP cycles produce results every NSTEP cycles.
- R7: The result is correct for L = 1, for L = M, and for an L that does not divide M.
- R8: `rst_n` is a synchronous active-low reset. It discards every pair in flight and ignores `in_valid` while low. `out_valid` stays low while reset is applied and until a pair accepted after reset reaches the end of the chain.
- R9: Cycles with `in_valid` low produce no `out_valid` pulse, whatever the operand inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | M | Multiplicand |
| in_b | input | M | Multiplier, consumed highest digit first |
| in_g | input | M | Field polynomial coefficients below x^M |
| out_valid | output | 1 | Result present this cycle |
| out_p | output | M | Reduced product |

## Verification
A corrupted partial product or a misrouted digit in one cell spoils every result that passes through that cell. It therefore shows as a wrong `out_p` at the port exactly NSTEP-1 edges after the affected pair was captured. A fault in the valid path shows within the same window, as a pulse that is missing, duplicated or displaced relative to the capture edge. State left behind after reset, or a bubble turned into a result, shows as an `out_valid` pulse during a window in which no pair was presented. Exact checks against known products in the 8-bit field pin down the basis and bit-order conventions.

// File: rtl/gf_dsm_pkg.sv
// Shared helpers for the digit-serial field multiplier.
// Assumes positive arguments; no state.
package gf_dsm_pkg;

    // Number of digit steps needed to cover m bits in digits of l bits.
    function automatic int num_steps(input int m, input int l);
        return (m + l - 1) / l;
    endfunction

endpackage

// File: rtl/gf_dsm_xtime.sv
// Multiply a field element by x and reduce once.
// Assumes M >= 2 and that g carries the coefficients below x^M.
module gf_dsm_xtime #(
    parameter int M = 13
) (
    input  logic [M-1:0] p_in,
    input  logic [M-1:0] g,
    output logic [M-1:0] p_out
);

    logic [M-1:0] shifted;
    logic [M-1:0] fold;

    // Shift up by one position; the bit leaving the top selects a fold of g.
    always_comb begin
        shifted = {p_in[M-2:0], 1'b0};
        fold    = p_in[M-1] ? g : '0;
        p_out   = shifted ^ fold;
    end

endmodule

// File: rtl/gf_dsm_step.sv
// One digit step: p_out = (p_in * x^L + a * d) mod G, where d is an L-bit
// digit whose bit L-1 is the highest. The reduction is applied one bit at a
// time, so the digit is worked highest bit first in L xtime stages.
// Assumes L >= 1 and a already reduced (degree below M).
module gf_dsm_step #(
    parameter int M = 13,
    parameter int L = 4
) (
    input  logic [M-1:0] p_in,
    input  logic [M-1:0] a,
    input  logic [M-1:0] g,
    input  logic [L-1:0] digit,
    output logic [M-1:0] p_out
);

    logic [M-1:0] stage [0:L];
    logic [M-1:0] xt    [0:L-1];

    assign stage[0] = p_in;

    generate
        for (genvar j = 0; j < L; j++) begin : g_bit
            gf_dsm_xtime #(.M(M)) xt_i (
                .p_in  (stage[j]),
                .g     (g),
                .p_out (xt[j])
            );
            // Add the multiplicand when the current digit bit is set.
            assign stage[j+1] = xt[j] ^ ({M{digit[L-1-j]}} & a);
        end
    endgenerate

    assign p_out = stage[L];

endmodule

// File: rtl/gf_dsm_cell.sv
// Systolic cell: consumes the top digit of its multiplier copy, registers
// the new partial product and passes operands one cell downstream.
// Assumes W is a multiple of L. Data registers load only with a valid item.
module gf_dsm_cell #(
    parameter int M = 13,
    parameter int L = 4,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    input  logic [M-1:0] up_a,
    input  logic [M-1:0] up_g,
    input  logic [W-1:0] up_b,
    input  logic [M-1:0] up_p,
    output logic         dn_valid,
    output logic [M-1:0] dn_a,
    output logic [M-1:0] dn_g,
    output logic [W-1:0] dn_b,
    output logic [M-1:0] dn_p
);

    logic [L-1:0] digit;
    logic [M-1:0] p_next;

    // The digit handled here is always the top L bits of the incoming copy.
    assign digit = up_b[W-1 -: L];

    gf_dsm_step #(.M(M), .L(L)) step_i (
        .p_in  (up_p),
        .a     (up_a),
        .g     (up_g),
        .digit (digit),
        .p_out (p_next)
    );

    // Valid bit: cleared by reset, otherwise follows the upstream cell.
    always_ff @(posedge clk) begin
        if (!rst_n) dn_valid <= 1'b0;
        else        dn_valid <= up_valid;
    end

    // Data registers: cleared by reset, loaded only for a valid item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_a <= '0;
            dn_g <= '0;
            dn_b <= '0;
            dn_p <= '0;
        end else if (up_valid) begin
            dn_a <= up_a;
            dn_g <= up_g;
            dn_b <= up_b << L;
            dn_p <= p_next;
        end
    end

endmodule

// File: rtl/gf_dsm_mul.sv
// Digit-serial field multiplier, top level. Builds NSTEP = ceil(M/L)
// cells in a one-way chain. The multiplier is zero-extended at the top to
// NSTEP*L bits, so padding digits are consumed first and add nothing.
// Assumes M >= 2, 1 <= L <= M, and an irreducible field polynomial.
module gf_dsm_mul #(
    parameter int M = 13,
    parameter int L = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] in_a,
    input  logic [M-1:0] in_b,
    input  logic [M-1:0] in_g,
    output logic         out_valid,
    output logic [M-1:0] out_p
);

    localparam int NSTEP = gf_dsm_pkg::num_steps(M, L);
    localparam int W     = NSTEP * L;

    logic         v_c [0:NSTEP];
    logic [M-1:0] a_c [0:NSTEP];
    logic [M-1:0] g_c [0:NSTEP];
    logic [W-1:0] b_c [0:NSTEP];
    logic [M-1:0] p_c [0:NSTEP];

    // Chain head: operands enter with an empty partial product.
    assign v_c[0] = in_valid;
    assign a_c[0] = in_a;
    assign g_c[0] = in_g;
    assign b_c[0] = W'(in_b);
    assign p_c[0] = '0;

    generate
        for (genvar k = 0; k < NSTEP; k++) begin : g_cell
            gf_dsm_cell #(.M(M), .L(L), .W(W)) cell_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .up_valid (v_c[k]),
                .up_a     (a_c[k]),
                .up_g     (g_c[k]),
                .up_b     (b_c[k]),
                .up_p     (p_c[k]),
                .dn_valid (v_c[k+1]),
                .dn_a     (a_c[k+1]),
                .dn_g     (g_c[k+1]),
                .dn_b     (b_c[k+1]),
                .dn_p     (p_c[k+1])
            );
        end
    endgenerate

    // Chain tail drives the result ports.
    assign out_valid = v_c[NSTEP];
    assign out_p     = p_c[NSTEP];

endmodule

// File: rtl/gf_dsm_chk.sv
// Property checker for gf_dsm_mul. Tracks each captured pair over
// NSTEP edges in its own shift registers and checks timing and
// algebraic identities at the result ports. Attached by the bind below.
module gf_dsm_chk #(
    parameter int M = 13,
    parameter int L = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [M-1:0] in_a,
    input logic [M-1:0] in_b,
    input logic         out_valid,
    input logic [M-1:0] out_p
);

    localparam int N = gf_dsm_pkg::num_steps(M, L);

    logic         vld_sr [0:N-1];
    logic         zro_sr [0:N-1];
    logic         b1_sr  [0:N-1];
    logic         a1_sr  [0:N-1];
    logic [M-1:0] a_sr   [0:N-1];
    logic [M-1:0] b_sr   [0:N-1];

    // Expected valid timing: in_valid delayed over the chain length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) vld_sr[k] <= 1'b0;
        end else begin
            vld_sr[0] <= in_valid;
            for (int k = 1; k < N; k++) vld_sr[k] <= vld_sr[k-1];
        end
    end

    // Operand facts carried alongside each item.
    always_ff @(posedge clk) begin
        zro_sr[0] <= (in_a == '0) || (in_b == '0);
        b1_sr[0]  <= (in_b == M'(1));
        a1_sr[0]  <= (in_a == M'(1));
        a_sr[0]   <= in_a;
        b_sr[0]   <= in_b;
        for (int k = 1; k < N; k++) begin
            zro_sr[k] <= zro_sr[k-1];
            b1_sr[k]  <= b1_sr[k-1];
            a1_sr[k]  <= a1_sr[k-1];
            a_sr[k]   <= a_sr[k-1];
            b_sr[k]   <= b_sr[k-1];
        end
    end

    // R4
    lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_sr[N-1]);

    // R8
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_valid);

    // R3
    zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zro_sr[N-1]) |-> (out_p == '0));

    // R2
    unit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && b1_sr[N-1]) |-> (out_p == a_sr[N-1]));

    // R2
    unit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && a1_sr[N-1]) |-> (out_p == b_sr[N-1]));

endmodule

bind gf_dsm_mul gf_dsm_chk #(.M(M), .L(L)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_p     (out_p)
);

// File: tb/gf_dsm_mon.sv
// Bench-side scoreboard for one multiplier instance. The reference forms
// the full carry-less product and then reduces it by long division.
module gf_dsm_mon #(
    parameter int M = 13,
    parameter int L = 4
) (
    input logic         clk,
    input logic         out_valid,
    input logic [M-1:0] out_p,
    input int           cyc
);

    localparam int NSTEP = (M + L - 1) / L;

    logic [M-1:0] exp_q [0:255];
    int           tag_q [0:255];
    int wr = 0;
    int rd = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_out = 0;
    int n_keep = 0;
    int exp_gap = 0;
    int last_cyc = 0;
    bit have_last = 0;

    // Full product, then reduction from the top coefficient down.
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a,
                                             input logic [M-1:0] b,
                                             input logic [M-1:0] g);
        logic [2*M-1:0] prod;
        logic [2*M-1:0] modp;
        prod = '0;
        modp = {{(M-1){1'b0}}, 1'b1, g};
        for (int i = 0; i < M; i++)
            if (b[i]) prod = prod ^ ((2*M)'(a) << i);
        for (int k = 2*M-2; k >= M; k--)
            if (prod[k]) prod = prod ^ (modp << (k - M));
        return prod[M-1:0];
    endfunction

    // Queue one expected result with the edge number that captures it.
    task automatic push(input logic [M-1:0] a, input logic [M-1:0] b,
                        input logic [M-1:0] g, input int tag);
        exp_q[wr % 256] = ref_mul(a, b, g);
        tag_q[wr % 256] = tag;
        wr = wr + 1;
        n_keep = n_keep + 1;
    endtask

    // Drop everything in flight (used around reset).
    task automatic flush();
        n_keep = n_keep - (wr - rd);
        rd = wr;
        have_last = 0;
    endtask

    // Check each result's value, latency and spacing.
    always @(negedge clk) begin
        if (out_valid) begin
            n_out = n_out + 1;
            n_chk = n_chk + 1;
            if (rd == wr) begin
                n_fail = n_fail + 1;
                $display("FAIL R5 M=%0d L=%0d unexpected result act=%h exp=none",
                         M, L, out_p);
            end else begin
                if (out_p !== exp_q[rd % 256]) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R1 M=%0d L=%0d product act=%h exp=%h",
                             M, L, out_p, exp_q[rd % 256]);
                end
                n_chk = n_chk + 1;
                if (cyc - tag_q[rd % 256] != NSTEP - 1) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R4 M=%0d L=%0d latency act=%0d exp=%0d",
                             M, L, cyc - tag_q[rd % 256], NSTEP - 1);
                end
                rd = rd + 1;
            end
            if (exp_gap > 0 && have_last) begin
                n_chk = n_chk + 1;
                if (cyc - last_cyc != exp_gap) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R6 M=%0d L=%0d spacing act=%0d exp=%0d",
                             M, L, cyc - last_cyc, exp_gap);
                end
            end
            last_cyc = cyc;
            have_last = 1;
        end
    end

endmodule

// File: tb/gf_dsm_mul_tb_top.sv
// Bench: three configurations share one stimulus stream.
module gf_dsm_mul_tb_top;

    localparam int CLK_PERIOD = 10;

    // {a, b} pairs for the 13-bit field; 8-bit instances use the low bits.
    localparam logic [25:0] VEC [0:11] = '{
        {13'h1FFF, 13'h1FFF}, {13'h0001, 13'h1ABC}, {13'h1ABC, 13'h0001},
        {13'h0000, 13'h1234}, {13'h1000, 13'h1000}, {13'h0057, 13'h0083},
        {13'h0F0F, 13'h10F0}, {13'h0002, 13'h1000}, {13'h1555, 13'h0AAA},
        {13'h0123, 13'h0000}, {13'h0800, 13'h0002}, {13'h1357, 13'h0ACE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [12:0] in_a = '0;
    logic [12:0] in_b = '0;
    logic [12:0] g13 = 13'h001B;
    logic [7:0]  g8 = 8'h1B;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    logic        ov_m, ov_s, ov_w;
    logic [12:0] op_m;
    logic [7:0]  op_s, op_w;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // 13-bit field, 4-bit digits (L does not divide M), NSTEP = 4.
    gf_dsm_mul #(.M(13), .L(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
        .in_b(in_b), .in_g(g13), .out_valid(ov_m), .out_p(op_m));
    // 8-bit field, bit-serial digits, NSTEP = 8.
    gf_dsm_mul #(.M(8), .L(1)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a[7:0]),
        .in_b(in_b[7:0]), .in_g(g8), .out_valid(ov_s), .out_p(op_s));
    // 8-bit field, one digit covers the whole operand, NSTEP = 1.
    gf_dsm_mul #(.M(8), .L(8)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a[7:0]),
        .in_b(in_b[7:0]), .in_g(g8), .out_valid(ov_w), .out_p(op_w));

    gf_dsm_mon #(.M(13), .L(4)) mon_m_i (.clk(clk), .out_valid(ov_m), .out_p(op_m), .cyc(cyc));
    gf_dsm_mon #(.M(8), .L(1)) mon_s_i (.clk(clk), .out_valid(ov_s), .out_p(op_s), .cyc(cyc));
    gf_dsm_mon #(.M(8), .L(8)) mon_w_i (.clk(clk), .out_valid(ov_w), .out_p(op_w), .cyc(cyc));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        int tot;
        int bad;
        tot = n_chk + mon_m_i.n_chk + mon_s_i.n_chk + mon_w_i.n_chk;
        bad = n_fail + mon_m_i.n_fail + mon_s_i.n_fail + mon_w_i.n_fail;
        $display("%0d/%0d checks passed", tot - bad, tot);
        $finish;
    endtask

    // Present one pair for one cycle; called at a falling edge.
    task automatic send(input logic [12:0] a, input logic [12:0] b);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        mon_m_i.push(a, b, g13, cyc + 1);
        mon_s_i.push(a[7:0], b[7:0], g8, cyc + 1);
        mon_w_i.push(a[7:0], b[7:0], g8, cyc + 1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet_check(input string req, input string what);
        chk(!ov_m && !ov_s && !ov_w, req, what, {29'd0, ov_m, ov_s, ov_w}, 32'd0);
    endtask

    // Watchdog: a hung run ends as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog act=expired exp=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs quiet while reset is held
        quiet_check("R8", "valid during reset");
        rst_n = 1'b1;
        @(negedge clk);
        quiet_check("R8", "valid right after reset");

        // R1 R7: known products in the 8-bit field, isolated pair
        send(13'h0057, 13'h0083);
        chk(ov_w && op_w == 8'hC1, "R1", "L=8 0x57*0x83", {23'd0, ov_w, op_w}, {23'd0, 1'b1, 8'hC1});
        idle(3);
        chk(ov_m, "R4", "M=13 L=4 valid after 3 more edges", {31'd0, ov_m}, 32'd1);
        idle(4);
        chk(ov_s && op_s == 8'hC1, "R7", "L=1 0x57*0x83", {23'd0, ov_s, op_s}, {23'd0, 1'b1, 8'hC1});
        idle(4);
        send(13'h0057, 13'h0013);
        chk(ov_w && op_w == 8'hFE, "R1", "L=8 0x57*0x13", {23'd0, ov_w, op_w}, {23'd0, 1'b1, 8'hFE});
        idle(10);

        // R5 R7: table walked back to back, one pair per cycle
        for (int i = 0; i < 12; i++) send(VEC[i][25:13], VEC[i][12:0]);
        idle(12);

        // R6: pairs every NSTEP (=4) cycles give results 4 cycles apart
        mon_m_i.exp_gap = 4; mon_m_i.have_last = 0;
        mon_s_i.exp_gap = 4; mon_s_i.have_last = 0;
        mon_w_i.exp_gap = 4; mon_w_i.have_last = 0;
        for (int i = 0; i < 6; i++) begin
            send(VEC[11-i][25:13], VEC[11-i][12:0]);
            idle(3);
        end
        idle(12);
        mon_m_i.exp_gap = 0;
        mon_s_i.exp_gap = 0;
        mon_w_i.exp_gap = 0;

        // R2: unit operands; R3: zero operands (also checked in the monitors)
        send(13'h0001, 13'h1F3C);
        send(13'h0B7D, 13'h0001);
        send(13'h0000, 13'h1FFF);
        send(13'h1FFF, 13'h0000);
        send(13'h1000, 13'h0100);
        idle(12);

        // R8: reset in flight discards pairs and ignores in_valid
        send(13'h0ABC, 13'h1DEF);
        send(13'h1111, 13'h0222);
        in_valid = 1'b1;
        in_a = 13'h0333;
        in_b = 13'h0444;
        rst_n = 1'b0;
        @(negedge clk);
        mon_m_i.flush();
        mon_s_i.flush();
        mon_w_i.flush();
        for (int i = 0; i < 3; i++) begin
            quiet_check("R8", "valid while reset with in_valid high");
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            quiet_check("R8", "valid after reset, nothing sent");
            @(negedge clk);
        end

        // R9: moving operands without in_valid create no result
        for (int i = 0; i < 12; i++) begin
            in_a = 13'(i * 977 + 5);
            in_b = 13'(i * 1231 + 9);
            quiet_check("R9", "valid with in_valid low");
            @(negedge clk);
        end

        // R1: traffic after reset still correct
        send(13'h1ACE, 13'h0BED);
        send(13'h0057, 13'h0083);
        idle(12);

        // R5: every pair kept produced exactly one result per instance
        chk(mon_m_i.n_out == mon_m_i.n_keep, "R5", "M=13 result count", mon_m_i.n_out, mon_m_i.n_keep);
        chk(mon_s_i.n_out == mon_s_i.n_keep, "R5", "L=1 result count", mon_s_i.n_out, mon_s_i.n_keep);
        chk(mon_w_i.n_out == mon_w_i.n_keep, "R5", "L=8 result count", mon_w_i.n_out, mon_w_i.n_keep);
        report();
    end

endmodule